// File: doc/BRIEF.md
# Serial Management Slave with PHY Register File

This block is the management side of an Ethernet physical-layer device. It runs on the management clock (MDC) and watches a shared, open-drain management data line. It picks out read and write frames that carry its own 5-bit device address, and serves them from a small register file: a control word, a status word and a two-word identifier. Each device on a shared line gets its own address from a strap input, and frames for other addresses are left alone.

The register file is the handshake between management software and the rest of the PHY. The soft-reset and negotiation-restart command bits hold a request line high until the engine answers. Duplex and speed settings reach the datapath through outputs. A jabber event is latched until software reads the status word. The identifier words are built at elaboration from an organisation code, a model number and a revision. The line can be driven by several devices, so the block keeps a separate data output and output enable, and the pad logic combines them.

Frame format: an optional preamble of ones, then start bits `01`, then opcode (`10` read, `01` write), then device address, then register address, each field MSB first. After that come 2 turnaround bits and 16 data bits, MSB first. Register addresses: 0 control, 1 status, 2 identifier high, 3 identifier low.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame whose device address differs from `phy_addr` is ignored: `mdio_oe` stays 0 for the whole frame and a write changes no register.
- R2: On a matching read, `mdio_oe` is 0 during the first turnaround bit. During the second turnaround bit the line is driven to 0. The 16 data bits follow MSB first, and the line is released after the last data bit.
- R3: On a matching write, the 16 data bits are committed to the addressed register at the edge that samples the last data bit.
- R4: Frames are accepted both with a 32-bit preamble of ones and with no preamble at all.
- R5: Writing 1 to control bit 15 raises `soft_rst_req`, and bit 15 reads 1 until a cycle with `soft_rst_done` high. At that edge the control word returns to its default 0x3000 and the request drops.
- R6: Writing 1 to control bit 9 together with bit 12 = 1 raises `an_restart_req`. Bit 9 reads 1 until a cycle with `an_started` high. If bit 12 is written 0, bit 9 has no effect and reads 0.
- R7: `duplex_full` follows control bit 8 only while control bit 12 is 0. While bit 12 is 1 it follows `an_duplex`.
- R8: Status bit 1 is set by `jabber_in` only while `is_10m` is 1. It stays set until a status read, which returns 1 and clears it, so the next status read returns 0.
- R9: Identifier-high bit (15-i) holds organisation-code bit (3+i), for i = 0..15, where code bit n is parameter bit n-1. In identifier-low, bits 15:10 hold code bits 19..24 in the same order, bits 9:4 hold the model number and bits 3:0 hold the revision.
- R10: The status word is 0x0049 with bit 5 = `an_done`, bit 2 = `link_up` and bit 1 = the jabber latch. Bit 6 reports that frames without a preamble are accepted.
- R11: Reserved control bits (14, 10, 7:0) read 0 and ignore writes. Addresses 4 to 31 read 0, and writes to them are discarded.
- R12: With control bit 11 (power-down) set, `power_down` is 1 and reads and writes are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; the line is sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr | input | 5 | Strapped device address |
| mdio_i | input | 1 | Management data line as seen at the pad |
| mdio_o | output | 1 | Data driven onto the line during reads |
| mdio_oe | output | 1 | Output enable for the line driver |
| soft_rst_done | input | 1 | Reset sequence finished |
| an_started | input | 1 | Negotiation engine has started a new round |
| an_done | input | 1 | Negotiation complete, reported in status |
| an_duplex | input | 1 | Duplex chosen by negotiation |
| link_up | input | 1 | Link state, reported in status |
| is_10m | input | 1 | PHY is running at 10 Mb/s |
| jabber_in | input | 1 | Jabber event pulse |
| soft_rst_req | output | 1 | Soft reset requested |
| an_restart_req | output | 1 | Negotiation restart requested |
| an_enable | output | 1 | Negotiation enabled |
| duplex_full | output | 1 | Effective full duplex |
| speed_100 | output | 1 | Forced speed select |
| power_down | output | 1 | Power-down requested |

## Verification
The bench checks the turnaround bits cycle by cycle. If the slave drove the first turnaround bit, or dropped the enable late, it would fight the master or the next device on the shared line. If it went quiet on frames for other addresses only after some delay, `mdio_oe` would be seen high outside its own frames. The bench then reads the jabber latch twice in a row and checks the restart bit with negotiation disabled. A latch that cleared on the wrong edge would lose the event. A restart bit without gating would leave a request that no engine answers. Random control writes and writes to other addresses or unused registers are checked against a bench model of the control word, so a leak through reserved bits or a stray commit shows up in the next read.

// File: rtl/mdio_pkg.sv
// Shared types and helpers for the serial management slave.
// Assumes organisation-code bit n (1-based) sits at parameter bit n-1.
package mdio_pkg;
    typedef enum logic [2:0] {F_IDLE, F_START, F_HDR, F_TA, F_DATA} fstate_t;

    localparam logic [4:0] A_CTRL = 5'd0;
    localparam logic [4:0] A_STAT = 5'd1;
    localparam logic [4:0] A_ID_H = 5'd2;
    localparam logic [4:0] A_ID_L = 5'd3;

    localparam int HDR_BITS  = 12;
    localparam int DATA_BITS = 16;

    // Identifier-high: code bits 3..18 into register bits 15..0.
    function automatic logic [15:0] id_hi_map(input logic [23:0] oui);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[15-i] = oui[2+i];
        return r;
    endfunction

    // Identifier-low: code bits 19..24 into 15..10, then model and revision.
    function automatic logic [15:0] id_lo_map(input logic [23:0] oui,
                                              input logic [5:0] model,
                                              input logic [3:0] rev);
        logic [15:0] r;
        for (int i = 0; i < 6; i++) r[15-i] = oui[18+i];
        r[9:4] = model;
        r[3:0] = rev;
        return r;
    endfunction
endpackage

// File: rtl/mdio_frame.sv
// Serial frame engine: finds start bits, shifts in the header, runs the
// turnaround and shifts the 16-bit data field in or out.
// Assumes the line idles high and is sampled on the rising edge of mdc;
// driven bits change on the rising edge so the master sees them on the next.
module mdio_frame
    import mdio_pkg::*;
(
    input  logic        mdc,
    input  logic        rst_n,
    input  logic [4:0]  phy_addr,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [4:0]  reg_addr,
    output logic        rd_stb,
    input  logic [15:0] rd_data,
    output logic        wr_stb,
    output logic [15:0] wr_data
);
    localparam int CW = $clog2(DATA_BITS);

    fstate_t        state;
    logic [CW-1:0]  cnt;
    logic [15:0]    sh;
    logic [4:0]     addr_q;
    logic           is_rd, is_wr;
    logic [11:0]    hdr;
    logic           hdr_match, hdr_rd, hdr_wr, hdr_last;

    // Header word as it stands at the edge sampling its last bit.
    always_comb begin
        hdr       = {sh[10:0], mdio_i};
        hdr_match = (hdr[9:5] == phy_addr);
        hdr_rd    = hdr_match && (hdr[11:10] == 2'b10);
        hdr_wr    = hdr_match && (hdr[11:10] == 2'b01);
        hdr_last  = (state == F_HDR) && (cnt == CW'(HDR_BITS - 1));
    end

    // Strobes and address presented to the register file.
    always_comb begin
        reg_addr = (state == F_HDR) ? hdr[4:0] : addr_q;
        rd_stb   = hdr_last && hdr_rd;
        wr_stb   = (state == F_DATA) && (cnt == CW'(DATA_BITS - 1)) && is_wr;
        wr_data  = {sh[14:0], mdio_i};
    end

    // Frame sequencer and line driver.
    always_ff @(posedge mdc) begin
        if (!rst_n) begin
            state   <= F_IDLE;
            cnt     <= '0;
            sh      <= '0;
            addr_q  <= '0;
            is_rd   <= 1'b0;
            is_wr   <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            case (state)
                F_IDLE: if (!mdio_i) state <= F_START;
                F_START: begin
                    cnt   <= '0;
                    state <= mdio_i ? F_HDR : F_IDLE;
                end
                F_HDR: begin
                    sh  <= {sh[14:0], mdio_i};
                    cnt <= cnt + 1'b1;
                    if (hdr_last) begin
                        is_rd  <= hdr_rd;
                        is_wr  <= hdr_wr;
                        addr_q <= hdr[4:0];
                        if (hdr_rd) sh <= rd_data;
                        cnt    <= '0;
                        state  <= F_TA;
                    end
                end
                F_TA: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == '0) begin
                        mdio_oe <= is_rd;
                        mdio_o  <= 1'b0;
                    end else begin
                        mdio_o <= sh[15];
                        sh     <= {sh[14:0], mdio_i};
                        cnt    <= '0;
                        state  <= F_DATA;
                    end
                end
                F_DATA: begin
                    mdio_o <= sh[15];
                    sh     <= {sh[14:0], mdio_i};
                    cnt    <= cnt + 1'b1;
                    if (cnt == CW'(DATA_BITS - 1)) begin
                        mdio_oe <= 1'b0;
                        is_rd   <= 1'b0;
                        is_wr   <= 1'b0;
                        state   <= F_IDLE;
                    end
                end
                default: state <= F_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phy_regs.sv
// Control, status and identifier registers with self-clearing command bits
// and a clear-on-read jabber latch.
// Assumes rd_stb/wr_stb are single-cycle and reg_addr is valid with them.
module phy_regs
    import mdio_pkg::*;
#(
    parameter logic [23:0] OUI   = 24'hA5C396,
    parameter logic [5:0]  MODEL = 6'h2B,
    parameter logic [3:0]  REV   = 4'h9
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_addr,
    input  logic        rd_stb,
    output logic [15:0] rd_data,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    input  logic        soft_rst_done,
    input  logic        an_started,
    input  logic        an_done,
    input  logic        an_duplex,
    input  logic        link_up,
    input  logic        is_10m,
    input  logic        jabber_in,
    output logic        soft_rst_req,
    output logic        an_restart_req,
    output logic        an_enable,
    output logic        duplex_full,
    output logic        speed_100,
    output logic        power_down
);
    localparam logic [15:0] ID_HI = id_hi_map(OUI);
    localparam logic [15:0] ID_LO = id_lo_map(OUI, MODEL, REV);

    logic sr_pend, an_pend, jab, spd, ane, pd, dup;
    logic ctrl_wr;
    logic unused_bits;

    assign ctrl_wr     = wr_stb && (reg_addr == A_CTRL);
    assign unused_bits = ^{wr_data[14], wr_data[10], wr_data[7:0]};

    // Control fields, command handshakes and jabber latch.
    always_ff @(posedge clk) begin
        if (!rst_n || (soft_rst_done && sr_pend)) begin
            spd     <= 1'b1;
            ane     <= 1'b1;
            pd      <= 1'b0;
            dup     <= 1'b0;
            sr_pend <= 1'b0;
            an_pend <= 1'b0;
            jab     <= 1'b0;
        end else begin
            if (an_started) an_pend <= 1'b0;
            if (ctrl_wr) begin
                spd <= wr_data[13];
                ane <= wr_data[12];
                pd  <= wr_data[11];
                dup <= wr_data[8];
                if (wr_data[15]) sr_pend <= 1'b1;
                if (!wr_data[12])    an_pend <= 1'b0;
                else if (wr_data[9]) an_pend <= 1'b1;
            end
            if (jabber_in && is_10m)               jab <= 1'b1;
            else if (rd_stb && reg_addr == A_STAT) jab <= 1'b0;
        end
    end

    // Read multiplexer; unimplemented addresses return zero.
    always_comb begin
        case (reg_addr)
            A_CTRL:  rd_data = {sr_pend, 1'b0, spd, ane, pd, 1'b0, an_pend, dup, 8'h00};
            A_STAT:  rd_data = {9'b0, 1'b1, an_done, 1'b0, 1'b1, link_up, jab, 1'b1};
            A_ID_H:  rd_data = ID_HI;
            A_ID_L:  rd_data = ID_LO;
            default: rd_data = 16'h0000;
        endcase
    end

    // Outputs to the rest of the PHY.
    always_comb begin
        soft_rst_req   = sr_pend;
        an_restart_req = an_pend;
        an_enable      = ane;
        duplex_full    = ane ? an_duplex : dup;
        speed_100      = spd;
        power_down     = pd;
    end
endmodule

// File: rtl/mdio_mgmt_slave.sv
// Top of the serial management slave: frame engine plus register file.
// Assumes an external open-drain pad combines mdio_o/mdio_oe with a pull-up.
module mdio_mgmt_slave #(
    parameter logic [23:0] OUI   = 24'hA5C396,
    parameter logic [5:0]  MODEL = 6'h2B,
    parameter logic [3:0]  REV   = 4'h9
) (
    input  logic       mdc,
    input  logic       rst_n,
    input  logic [4:0] phy_addr,
    input  logic       mdio_i,
    output logic       mdio_o,
    output logic       mdio_oe,
    input  logic       soft_rst_done,
    input  logic       an_started,
    input  logic       an_done,
    input  logic       an_duplex,
    input  logic       link_up,
    input  logic       is_10m,
    input  logic       jabber_in,
    output logic       soft_rst_req,
    output logic       an_restart_req,
    output logic       an_enable,
    output logic       duplex_full,
    output logic       speed_100,
    output logic       power_down
);
    logic [4:0]  reg_addr;
    logic        rd_stb, wr_stb;
    logic [15:0] rd_data, wr_data;

    mdio_frame u_frame (
        .mdc(mdc), .rst_n(rst_n), .phy_addr(phy_addr), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_addr(reg_addr),
        .rd_stb(rd_stb), .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data)
    );

    phy_regs #(.OUI(OUI), .MODEL(MODEL), .REV(REV)) u_regs (
        .clk(mdc), .rst_n(rst_n), .reg_addr(reg_addr), .rd_stb(rd_stb),
        .rd_data(rd_data), .wr_stb(wr_stb), .wr_data(wr_data),
        .soft_rst_done(soft_rst_done), .an_started(an_started),
        .an_done(an_done), .an_duplex(an_duplex), .link_up(link_up),
        .is_10m(is_10m), .jabber_in(jabber_in),
        .soft_rst_req(soft_rst_req), .an_restart_req(an_restart_req),
        .an_enable(an_enable), .duplex_full(duplex_full),
        .speed_100(speed_100), .power_down(power_down)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Property checker for the management slave, attached by bind.
module mdio_mgmt_chk (
    input logic mdc,
    input logic rst_n,
    input logic mdio_o,
    input logic mdio_oe,
    input logic soft_rst_done,
    input logic an_started,
    input logic an_enable,
    input logic an_duplex,
    input logic duplex_full,
    input logic soft_rst_req,
    input logic an_restart_req
);
    // R2
    ta_drives_zero_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // R5
    sr_holds_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (soft_rst_req && !soft_rst_done) |=> soft_rst_req);

    // R5
    sr_clears_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (soft_rst_req && soft_rst_done) |=> !soft_rst_req);

    // R6
    restart_gated_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        !an_enable |-> !an_restart_req);

    // R6
    restart_ack_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        (an_started && !soft_rst_req) |=> (!an_restart_req || $rose(an_restart_req)));

    // R7
    duplex_an_chk: assert property (@(posedge mdc) disable iff (!rst_n)
        an_enable |-> (duplex_full == an_duplex));
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk u_chk (
    .mdc(mdc), .rst_n(rst_n), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .soft_rst_done(soft_rst_done), .an_started(an_started),
    .an_enable(an_enable), .an_duplex(an_duplex), .duplex_full(duplex_full),
    .soft_rst_req(soft_rst_req), .an_restart_req(an_restart_req)
);

// File: tb/tb_mdio_mgmt_slave.sv
module tb_mdio_mgmt_slave;
    localparam logic [23:0] OUI   = 24'hA5C396;
    localparam logic [5:0]  MODEL = 6'h2B;
    localparam logic [3:0]  REV   = 4'h9;
    localparam logic [4:0]  MY    = 5'h0B;

    logic mdc = 1'b0;
    logic rst_n = 1'b0;
    logic m_en = 1'b0, m_drv = 1'b1;
    logic soft_rst_done = 0, an_started = 0, an_done = 0, an_duplex = 0;
    logic link_up = 0, is_10m = 0, jabber_in = 0;
    logic mdio_o, mdio_oe, mdio_bus;
    logic soft_rst_req, an_restart_req, an_enable, duplex_full, speed_100, power_down;

    int tests = 0, fails = 0;
    bit finished = 0;

    // bench model of the control word
    logic m_spd = 1, m_ane = 1, m_pd = 0, m_dup = 0, m_anp = 0;

    always #2 mdc = ~mdc;
    assign mdio_bus = mdio_oe ? mdio_o : (m_en ? m_drv : 1'b1);

    mdio_mgmt_slave #(.OUI(OUI), .MODEL(MODEL), .REV(REV)) dut (
        .mdc(mdc), .rst_n(rst_n), .phy_addr(MY), .mdio_i(mdio_bus),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .soft_rst_done(soft_rst_done),
        .an_started(an_started), .an_done(an_done), .an_duplex(an_duplex),
        .link_up(link_up), .is_10m(is_10m), .jabber_in(jabber_in),
        .soft_rst_req(soft_rst_req), .an_restart_req(an_restart_req),
        .an_enable(an_enable), .duplex_full(duplex_full),
        .speed_100(speed_100), .power_down(power_down)
    );

    function automatic logic [15:0] exp_ctrl();
        return {1'b0, 1'b0, m_spd, m_ane, m_pd, 1'b0, m_anp, m_dup, 8'h00};
    endfunction

    function automatic logic [15:0] exp_stat(input logic jb);
        logic [15:0] v = 16'h0049;
        v[5] = an_done; v[2] = link_up; v[1] = jb;
        return v;
    endfunction

    function automatic logic [15:0] exp_idh();
        logic [15:0] v;
        for (int n = 3; n <= 18; n++) v[18-n] = OUI[n-1];
        return v;
    endfunction

    function automatic logic [15:0] exp_idl();
        logic [15:0] v = {6'b0, MODEL, REV};
        for (int n = 19; n <= 24; n++) v[34-n] = OUI[n-1];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge mdc);
        m_en = 1'b1;
        m_drv = b;
    endtask

    // One management frame; returns read data and line observations.
    task automatic mframe(input bit pre, input bit rd, input logic [4:0] pa,
                          input logic [4:0] ra, input logic [15:0] wd,
                          output logic [15:0] q, output int oe_cnt, output bit ta_ok);
        q = '0; oe_cnt = 0; ta_ok = 1;
        if (pre) for (int i = 0; i < 32; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        send_bit(rd ? 1'b1 : 1'b0); send_bit(rd ? 1'b0 : 1'b1);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
        if (rd) begin
            @(negedge mdc); m_en = 1'b0;
            if (mdio_oe) ta_ok = 0;
            @(negedge mdc);
            if (mdio_oe) oe_cnt++;
            if (!(mdio_oe && !mdio_o) && pa == MY) ta_ok = 0;
            for (int i = 0; i < 16; i++) begin
                @(negedge mdc);
                if (mdio_oe) oe_cnt++;
                q = {q[14:0], mdio_bus};
            end
        end else begin
            send_bit(1'b1); send_bit(1'b0);
            for (int i = 15; i >= 0; i--) begin
                send_bit(wd[i]);
                if (mdio_oe) oe_cnt++;
            end
        end
        @(negedge mdc); m_en = 1'b0;
        if (mdio_oe) ta_ok = 0;
    endtask

    task automatic rd_chk(input string tag, input bit pre, input logic [4:0] ra,
                          input logic [15:0] exp);
        logic [15:0] q; int oc; bit ok;
        mframe(pre, 1, MY, ra, 16'h0, q, oc, ok);
        chk(tag, q, exp);
        chk("R2 turnaround and release", {31'b0, ok}, 32'd1);
    endtask

    task automatic wr(input bit pre, input logic [4:0] pa, input logic [4:0] ra,
                      input logic [15:0] d);
        logic [15:0] q; int oc; bit ok;
        mframe(pre, 0, pa, ra, d, q, oc, ok);
        if (oc != 0) chk("R1 no drive on write", oc, 0);
    endtask

    task automatic model_ctrl_wr(input logic [15:0] d);
        m_spd = d[13]; m_ane = d[12]; m_pd = d[11]; m_dup = d[8];
        if (!d[12]) m_anp = 0; else if (d[9]) m_anp = 1;
    endtask

    task automatic pulse(ref logic s);
        @(negedge mdc); s = 1'b1;
        @(negedge mdc); s = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] q; int oc; bit ok;
        logic [15:0] d;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge mdc);
        rst_n = 1'b1;
        @(negedge mdc);
        chk("R5 reset no request", {30'b0, soft_rst_req, mdio_oe}, 0);
        rd_chk("R5 reset ctrl default", 1, 5'd0, 16'h3000);
        rd_chk("R4 read without preamble", 0, 5'd0, 16'h3000);

        // R9 identifier words
        rd_chk("R9 id high", 0, 5'd2, exp_idh());
        rd_chk("R9 id low", 1, 5'd3, exp_idl());

        // R10 status fixed bits and live inputs
        an_done = 1; link_up = 1;
        rd_chk("R10 status", 0, 5'd1, exp_stat(0));
        an_done = 0; link_up = 0;
        rd_chk("R10 status low", 1, 5'd1, exp_stat(0));

        // R1 read for another address: never drives
        mframe(0, 1, MY ^ 5'h01, 5'd0, 16'h0, q, oc, ok);
        chk("R1 foreign read oe", oc, 0);
        chk("R1 foreign read release", {31'b0, ok}, 1);

        // R11 unimplemented address read/write
        rd_chk("R11 unimplemented read", 0, 5'd9, 16'h0000);

        // R8 jabber latch
        is_10m = 1; pulse(jabber_in);
        rd_chk("R8 jabber latched", 0, 5'd1, exp_stat(1));
        rd_chk("R8 jabber cleared by read", 0, 5'd1, exp_stat(0));
        is_10m = 0; pulse(jabber_in);
        rd_chk("R8 jabber ignored at 100M", 0, 5'd1, exp_stat(0));

        // R6 restart handshake
        wr(0, MY, 5'd0, 16'h1200); model_ctrl_wr(16'h1200);
        rd_chk("R6 restart pending", 0, 5'd0, 16'h1200);
        chk("R6 restart req", {31'b0, an_restart_req}, 1);
        pulse(an_started); m_anp = 0;
        rd_chk("R6 restart acked", 0, 5'd0, 16'h1000);
        wr(1, MY, 5'd0, 16'h0200); model_ctrl_wr(16'h0200);
        rd_chk("R6 restart ignored without enable", 0, 5'd0, 16'h0000);
        chk("R6 no req without enable", {31'b0, an_restart_req}, 0);

        // R7 duplex gating
        wr(0, MY, 5'd0, 16'h0100); model_ctrl_wr(16'h0100);
        an_duplex = 0; @(negedge mdc);
        chk("R7 forced duplex", {31'b0, duplex_full}, 1);
        wr(0, MY, 5'd0, 16'h1100); model_ctrl_wr(16'h1100);
        an_duplex = 0; @(negedge mdc);
        chk("R7 negotiated duplex 0", {31'b0, duplex_full}, 0);
        an_duplex = 1; @(negedge mdc);
        chk("R7 negotiated duplex 1", {31'b0, duplex_full}, 1);

        // R12 power-down keeps serving
        wr(0, MY, 5'd0, 16'h1800); model_ctrl_wr(16'h1800);
        chk("R12 power_down out", {31'b0, power_down}, 1);
        rd_chk("R12 read in power-down", 0, 5'd0, 16'h1800);
        rd_chk("R12 id in power-down", 1, 5'd2, exp_idh());

        // R5 soft reset
        wr(0, MY, 5'd0, 16'h8100);
        rd_chk("R5 reset bit reads 1", 0, 5'd0, 16'h8100);
        chk("R5 request up", {31'b0, soft_rst_req}, 1);
        pulse(soft_rst_done);
        m_spd = 1; m_ane = 1; m_pd = 0; m_dup = 0; m_anp = 0;
        rd_chk("R5 defaults after reset", 0, 5'd0, 16'h3000);
        chk("R5 request down", {31'b0, soft_rst_req}, 0);

        // Random traffic against the control-word model (R3, R1, R11)
        for (int it = 0; it < 30; it++) begin
            int kind = $urandom % 4;
            bit pre = $urandom % 2;
            d = 16'($urandom) & 16'h7FFF;
            case (kind)
                0, 1: begin wr(pre, MY, 5'd0, d); model_ctrl_wr(d); end
                2: wr(pre, MY ^ 5'(1 + $urandom % 31), 5'd0, d);
                default: wr(pre, MY, 5'(4 + $urandom % 28), d);
            endcase
            an_duplex = $urandom % 2;
            @(negedge mdc);
            if (kind < 2) rd_chk("R3 R11 write then read", pre, 5'd0, exp_ctrl());
            else if (kind == 2) rd_chk("R1 foreign write dropped", pre, 5'd0, exp_ctrl());
            else rd_chk("R11 unimplemented write dropped", pre, 5'd0, exp_ctrl());
            chk("R6 req matches model", {31'b0, an_restart_req}, {31'b0, m_anp});
            chk("R7 duplex model", {31'b0, duplex_full}, {31'b0, m_ane ? an_duplex : m_dup});
            chk("R3 speed and power outputs", {30'b0, speed_100, power_down}, {30'b0, m_spd, m_pd});
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule